// File: doc/BRIEF.md
# Dithered 17-Level Second-Order Noise-Shaping Modulator

This block is the digital noise shaper of an oversampled audio DAC. Each time the oversampling strobe fires, which happens 128 times per audio sample, it accepts one signed input word and advances a second-order feedback loop by one step. The loop holds two cascaded saturating integrators. The second integrator drives a quantizer that produces one of 17 output levels. Before quantization, a triangular-distribution dither value is added to whiten the quantization error. The code it emits is handed to a downstream element-matching DAC.

The dither is the sum of two uniform values taken from two independent maximal-length LFSRs. The LFSRs have different lengths and different nonzero seeds. Parameters set the input width, the level count, the integrator width and the dither amplitude, and select whether dither is built at all. The loop transfer is output = z^-2·input + (1 − z^-1)^2·error. Because the quantizer has many levels and both integrators clamp, the loop stays bounded up to full-scale input with no extra stability logic.

Top module: `dsm17_mod`

## Requirements
- R1: While `rst` is high, both integrators are cleared, `code_out` is 0 and `code_vld` is 0 on the next clock edge, whatever the strobe does.
- R2: `code_vld` is high for exactly the cycle after each cycle in which `smp_stb` is high. `code_out`, the integrators and the dither source do not change in cycles without a strobe.
- R3: `code_out` is a 5-bit two's-complement level that always lies in −8..+8. Level k stands for the value k·Q, where Q = 2^(IN_W−1)/8 (65536 by default).
- R4: The quantizer adds the dither to the second integrator's value and rounds the sum to the nearest multiple of Q, with halves going toward +∞. The result is then clamped to ±8.
- R5: On each strobe, the level y is taken from the integrator values held before the update. The updates are i1 ← i1 + x − y·Q and i2 ← i2 + i1_old − 2·y·Q. The output register takes y.
- R6: Each integrator clamps to ±(2^(INT_W−1) − 1) rather than wrapping, and never holds the most negative code.
- R7: With dither on, a constant input x gives codes whose sum over N strobes stays within 16 levels of N·x/Q.
- R8: With dither on and zero input, the output leaves level 0 on many strobes. With dither off, the same stimulus yields only level 0. Each dither value is the sum of two uniform terms, each spanning ±Q/2 scaled down by 2^DITH_ATTEN.
- R9: While a full-scale input of either sign is held, after settling the codes never take the opposite sign.
- R10: Reset reloads both LFSR seeds, so the same input after two separate resets produces the same code sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Oversampled sample strobe, 128 × audio rate |
| smp_in | input | IN_W | Signed input sample |
| code_out | output | CODE_W | Signed quantizer level, −8..+8 |
| code_vld | output | 1 | Marks a new level on `code_out` |

## Verification
On the narrow-integrator instance, integrator saturation and the quantizer's clamp at ±8 fall in the same strobe. Full-scale inputs of each sign are held, and the sign is then swapped abruptly, which drives both limits at once. Every strobe is compared against a bench model built from the R4 to R6 equations, and that model also records that saturation really occurred. A second pairing brings a reset during strobing together with the dither source, to show that the LFSRs restart together with the integrators.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

   typedef enum logic [0:0] {
      DSM_DITHER_OFF  = 1'b0,
      DSM_DITHER_TPDF = 1'b1
   } dsm_dither_e;

   // Feedback tap mask for a maximal-length Fibonacci LFSR of width w.
   function automatic logic [63:0] lfsr_mask(input int w);
      case (w)
         16:      return 64'h0000_0000_0000_D008;
         23:      return 64'h0000_0000_0042_0000;
         31:      return 64'h0000_0000_4800_0000;
         default: return 64'h0;
      endcase
   endfunction

endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
   parameter int          LW    = 23,
   parameter int unsigned SEED  = 1,
   parameter int          OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [OUT_W-1:0] top_o
);
   localparam logic [LW-1:0] MASK = LW'(dsm_pkg::lfsr_mask(LW));
   localparam logic [LW-1:0] INIT = LW'(SEED);

   if (MASK == '0) begin : g_bad_len
      $error("dsm_lfsr: unsupported length");
   end
   if (INIT == '0) begin : g_bad_seed
      $error("dsm_lfsr: seed must be nonzero");
   end
   if (OUT_W > LW) begin : g_bad_out
      $error("dsm_lfsr: output wider than register");
   end

   logic [LW-1:0] st_q;

   always_ff @(posedge clk) begin
      if (rst)      st_q <= INIT;
      else if (adv) st_q <= {st_q[LW-2:0], ^(st_q & MASK)};
   end

   assign top_o = st_q[LW-1 -: OUT_W];
endmodule

// File: rtl/dsm_tpdf_dither.sv
module dsm_tpdf_dither #(
   parameter int          STEP_SH    = 16,
   parameter int          DITH_ATTEN = 0,
   parameter int unsigned SEED_A     = 32'h0000_2B1D,
   parameter int unsigned SEED_B     = 32'h3C0F_5A01
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      adv,
   output logic signed [STEP_SH:0]   dith_o
);
   localparam int UW = STEP_SH - DITH_ATTEN;

   if (UW < 2) begin : g_bad_atten
      $error("dsm_tpdf_dither: attenuation leaves too few bits");
   end

   logic [UW-1:0]  ua, ub;
   logic signed [UW:0] tri_sum;

   dsm_lfsr #(.LW(23), .SEED(SEED_A), .OUT_W(UW)) u_src_a (
      .clk(clk), .rst(rst), .adv(adv), .top_o(ua));
   dsm_lfsr #(.LW(31), .SEED(SEED_B), .OUT_W(UW)) u_src_b (
      .clk(clk), .rst(rst), .adv(adv), .top_o(ub));

   // Two independent uniforms of span +-2^(UW-1): their sum is triangular.
   always_comb begin
      tri_sum = (UW+1)'($signed(ua)) + (UW+1)'($signed(ub));
      dith_o  = (STEP_SH+1)'(tri_sum);
   end
endmodule

// File: rtl/dsm_quant.sv
module dsm_quant #(
   parameter int INT_W    = 24,
   parameter int STEP_SH  = 16,
   parameter int HALF_LVL = 8,
   parameter int CODE_W   = 5
) (
   input  logic signed [INT_W-1:0]   val_i,
   input  logic signed [STEP_SH:0]   dith_i,
   output logic signed [CODE_W-1:0]  lvl_o
);
   localparam int SW = INT_W + 2;
   localparam logic signed [SW-1:0] HALF_STEP = SW'(1) <<< (STEP_SH - 1);
   localparam logic signed [SW-1:0] LIM_P     = SW'(HALF_LVL);
   localparam logic signed [SW-1:0] LIM_N     = -LIM_P;

   if (STEP_SH + 1 > INT_W) begin : g_bad_dw
      $error("dsm_quant: dither wider than integrator");
   end

   logic signed [SW-1:0] sum, rnd;

   always_comb begin
      sum = SW'(val_i) + SW'(dith_i);
      rnd = (sum + HALF_STEP) >>> STEP_SH;
      if (rnd > LIM_P)      lvl_o = CODE_W'(LIM_P);
      else if (rnd < LIM_N) lvl_o = CODE_W'(LIM_N);
      else                  lvl_o = CODE_W'(rnd);
   end
endmodule

// File: rtl/dsm_sat_integ.sv
module dsm_sat_integ #(
   parameter int INT_W = 24,
   parameter int IW    = 26
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic signed [IW-1:0]    add_i,
   input  logic signed [IW-1:0]    sub_i,
   output logic signed [INT_W-1:0] acc_o
);
   localparam int SW = IW + 2;
   localparam logic signed [SW-1:0] PMAX = SW'({(INT_W-1){1'b1}});
   localparam logic signed [SW-1:0] NMAX = -PMAX;

   if (IW < INT_W) begin : g_bad_iw
      $error("dsm_sat_integ: operand narrower than accumulator");
   end

   logic signed [SW-1:0]    raw;
   logic signed [INT_W-1:0] nxt;

   always_comb begin
      raw = SW'(acc_o) + SW'(add_i) - SW'(sub_i);
      if (raw > PMAX)      nxt = INT_W'(PMAX);
      else if (raw < NMAX) nxt = INT_W'(NMAX);
      else                 nxt = INT_W'(raw);
   end

   always_ff @(posedge clk) begin
      if (rst)     acc_o <= '0;
      else if (en) acc_o <= nxt;
   end
endmodule

// File: rtl/dsm17_mod.sv
module dsm17_mod #(
   parameter int                  IN_W        = 20,
   parameter int                  HALF_LVL    = 8,
   parameter int                  INT_W       = 24,
   parameter dsm_pkg::dsm_dither_e DITHER_MODE = dsm_pkg::DSM_DITHER_TPDF,
   parameter int                  DITH_ATTEN  = 0,
   parameter int unsigned         SEED_A      = 32'h0000_2B1D,
   parameter int unsigned         SEED_B      = 32'h3C0F_5A01,
   localparam int                 LVL_SH      = $clog2(HALF_LVL),
   localparam int                 CODE_W      = LVL_SH + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_stb,
   input  logic [IN_W-1:0]          smp_in,
   output logic signed [CODE_W-1:0] code_out,
   output logic                     code_vld
);
   localparam int STEP_SH = IN_W - 1 - LVL_SH;
   localparam int IW      = INT_W + 2;

   if ((1 << LVL_SH) != HALF_LVL) begin : g_bad_lvl
      $error("dsm17_mod: HALF_LVL must be a power of two");
   end
   if (INT_W < IN_W) begin : g_bad_int
      $error("dsm17_mod: integrators narrower than input");
   end
   if (STEP_SH < 2) begin : g_bad_step
      $error("dsm17_mod: input too narrow for level count");
   end

   logic signed [INT_W-1:0]  i1_q, i2_q;
   logic signed [STEP_SH:0]  dith;
   logic signed [CODE_W-1:0] lvl;
   logic signed [IW-1:0]     x_ext, i1_ext, fb1, fb2;

   if (DITHER_MODE == dsm_pkg::DSM_DITHER_TPDF) begin : g_dith
      dsm_tpdf_dither #(
         .STEP_SH(STEP_SH), .DITH_ATTEN(DITH_ATTEN),
         .SEED_A(SEED_A), .SEED_B(SEED_B)
      ) u_dith (
         .clk(clk), .rst(rst), .adv(smp_stb), .dith_o(dith));
   end else begin : g_nodith
      assign dith = '0;
   end

   dsm_quant #(
      .INT_W(INT_W), .STEP_SH(STEP_SH), .HALF_LVL(HALF_LVL), .CODE_W(CODE_W)
   ) u_quant (
      .val_i(i2_q), .dith_i(dith), .lvl_o(lvl));

   always_comb begin
      x_ext  = IW'($signed(smp_in));
      i1_ext = IW'(i1_q);
      fb1    = IW'(lvl) <<< STEP_SH;
      fb2    = fb1 <<< 1;
   end

   dsm_sat_integ #(.INT_W(INT_W), .IW(IW)) u_int1 (
      .clk(clk), .rst(rst), .en(smp_stb),
      .add_i(x_ext), .sub_i(fb1), .acc_o(i1_q));

   dsm_sat_integ #(.INT_W(INT_W), .IW(IW)) u_int2 (
      .clk(clk), .rst(rst), .en(smp_stb),
      .add_i(i1_ext), .sub_i(fb2), .acc_o(i2_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         code_out <= '0;
         code_vld <= 1'b0;
      end else begin
         code_vld <= smp_stb;
         if (smp_stb) code_out <= lvl;
      end
   end
endmodule

// File: rtl/dsm17_mod_chk.sv
module dsm17_mod_chk #(
   parameter int CODE_W   = 5,
   parameter int INT_W    = 24,
   parameter int HALF_LVL = 8
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     stb,
   input logic signed [CODE_W-1:0] code,
   input logic                     vld,
   input logic signed [INT_W-1:0]  i1,
   input logic signed [INT_W-1:0]  i2
);
   localparam logic signed [CODE_W-1:0] LP = CODE_W'(HALF_LVL);
   localparam logic signed [INT_W-1:0]  MOST_NEG = {1'b1, {(INT_W-1){1'b0}}};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (code == '0 && !vld && i1 == '0 && i2 == '0));

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      stb |=> vld);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !stb |=> (!vld && $stable(code) && $stable(i1) && $stable(i2)));

   // R3
   code_range_chk: assert property (@(posedge clk) disable iff (rst)
      vld |-> (code <= LP && code >= -LP));

   // R6
   sym_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (i1 != MOST_NEG && i2 != MOST_NEG));
endmodule

bind dsm17_mod dsm17_mod_chk #(
   .CODE_W(CODE_W), .INT_W(INT_W), .HALF_LVL(HALF_LVL)
) u_chk (
   .clk(clk), .rst(rst), .stb(smp_stb), .code(code_out), .vld(code_vld),
   .i1(i1_q), .i2(i2_q));

// File: tb/dsm17_mod_tb.sv
module dsm17_mod_tb;
   localparam longint QS = 65536;
   localparam int NV = 8;
   localparam int VX[NV] = '{0, 131072, -262144, 367001, 524287, -524288, 12345, -77777};
   localparam int VN[NV] = '{40, 60, 60, 80, 80, 80, 50, 50};
   localparam int VG[NV] = '{1, 1, 3, 1, 1, 2, 4, 1};

   logic clk = 1'b0, rst = 1'b1, stb = 1'b0;
   logic [19:0] xin = '0;
   logic signed [4:0] code_d, code_n, code_s;
   logic vld_d, vld_n, vld_s;

   int n_chk = 0, n_fail = 0;
   longint m1a, m2a, m1s, m2s;
   bit sat_hit;
   longint ya, ys;

   always #4 clk = ~clk;

   dsm17_mod u_dut (.clk(clk), .rst(rst), .smp_stb(stb), .smp_in(xin),
                    .code_out(code_d), .code_vld(vld_d));
   dsm17_mod #(.DITHER_MODE(dsm_pkg::DSM_DITHER_OFF)) u_nd (
      .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(xin),
      .code_out(code_n), .code_vld(vld_n));
   dsm17_mod #(.DITHER_MODE(dsm_pkg::DSM_DITHER_OFF), .INT_W(20)) u_sat (
      .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(xin),
      .code_out(code_s), .code_vld(vld_s));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint satv(input longint v, input longint lim, inout bit hit);
      if (v > lim) begin hit = 1; return lim; end
      if (v < -lim) begin hit = 1; return -lim; end
      return v;
   endfunction

   // Loop equations of R4/R5/R6 with zero dither.
   task automatic model_step(inout longint m1, inout longint m2, input int w,
                             input longint x, output longint y);
      longint lim, q, n1, n2;
      bit h;
      h = 0;
      lim = (64'sd1 <<< (w - 1)) - 1;
      q = (m2 + QS / 2) >>> 16;
      if (q > 8) q = 8;
      if (q < -8) q = -8;
      y = q;
      n1 = satv(m1 + x - y * QS, lim, h);
      n2 = satv(m2 + m1 - 2 * y * QS, lim, h);
      if (h && w == 20) sat_hit = 1;
      m1 = n1;
      m2 = n2;
   endtask

   task automatic apply_rst();
      @(negedge clk);
      rst = 1'b1;
      stb = 1'b1;
      repeat (3) @(negedge clk);
      stb = 1'b0;
      rst = 1'b0;
      m1a = 0; m2a = 0; m1s = 0; m2s = 0;
   endtask

   // One strobe followed by gap-1 idle cycles; returns dithered code.
   task automatic do_strobe(input longint x, input int gap, output longint yd);
      longint prev;
      @(negedge clk);
      xin = x[19:0];
      stb = 1'b1;
      model_step(m1a, m2a, 24, x, ya);
      model_step(m1s, m2s, 20, x, ys);
      @(negedge clk);
      stb = 1'b0;
      yd = code_d;
      check(code_n == ya, "R5 loop output", code_n, ya);
      check(code_s == ys, "R6 narrow loop with saturation", code_s, ys);
      check(vld_d && vld_n && vld_s, "R2 valid after strobe", vld_d, 1);
      check(code_d <= 8 && code_d >= -8, "R3 code range", code_d, 8);
      for (int g = 1; g < gap; g++) begin
         prev = code_d;
         @(negedge clk);
         check(!vld_d && code_d == prev, "R2 hold without strobe", code_d, prev);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      longint yd, sum;
      int nz_d, nz_n;
      longint seq[64];

      apply_rst();
      // R1: reset state, even with strobe held high during reset
      check(code_d == 0 && code_n == 0 && code_s == 0, "R1 reset code", code_d, 0);
      check(!vld_d && !vld_n && !vld_s, "R1 reset valid", vld_d, 0);

      // R2 R4 R5 R6 R9: vector table
      for (int r = 0; r < NV; r++) begin
         for (int k = 0; k < VN[r]; k++) begin
            do_strobe(VX[r], VG[r], yd);
            if (k >= 20 && VX[r] == 524287)
               check(yd >= 0 && code_n >= 0, "R9 positive full scale sign", yd, 8);
            if (k >= 20 && VX[r] == -524288)
               check(yd <= 0 && code_n <= 0, "R9 negative full scale sign", yd, -8);
         end
      end
      check(sat_hit, "R6 saturation reached in narrow loop", sat_hit, 1);

      // R1: reset mid-run clears integrators; model restarts from zero
      apply_rst();
      for (int k = 0; k < 30; k++) do_strobe(200000, 1, yd);
      check(code_n == ya, "R1 post-reset sequence", code_n, ya);

      // R8: zero input, dither on versus off
      apply_rst();
      nz_d = 0; nz_n = 0;
      for (int k = 0; k < 256; k++) begin
         do_strobe(0, 1, yd);
         if (yd != 0) nz_d++;
         if (code_n != 0) nz_n++;
      end
      check(nz_d > 16, "R8 dither moves idle output", nz_d, 17);
      check(nz_n == 0, "R8 undithered idle output", nz_n, 0);

      // R7: DC tracking with dither
      apply_rst();
      sum = 0;
      for (int k = 0; k < 512; k++) begin do_strobe(131072, 1, yd); sum += yd; end
      check(sum >= 1024 - 16 && sum <= 1024 + 16, "R7 mean +2 levels", sum, 1024);
      apply_rst();
      sum = 0;
      for (int k = 0; k < 512; k++) begin do_strobe(-216269, 1, yd); sum += yd; end
      check(sum >= -1689 - 16 && sum <= -1689 + 16, "R7 mean -3.3 levels", sum, -1689);

      // R10: dither restarts identically after reset
      apply_rst();
      for (int k = 0; k < 64; k++) begin do_strobe(37000, 1, yd); seq[k] = yd; end
      apply_rst();
      nz_d = 0;
      for (int k = 0; k < 64; k++) begin
         do_strobe(37000, 1, yd);
         if (yd != seq[k]) nz_d++;
      end
      check(nz_d == 0, "R10 repeat after reset", nz_d, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule